// File: doc/BRIEF.md
# Dynamic Bus Sizing Master Sequencer

This block sits on the master side of a parallel system bus. It takes one local access of up to four bytes and runs as many bus cycles as the addressed slave's data port needs. The local side presents an aligned word address, write data, four active-high byte enables, a read/write flag and a memory/IO flag. The sequencer drives an address and a status code, then reads the two active-low data-size lines that the slave returns. From these it decides whether the port is 8, 16 or 32 bits wide. It then issues byte cycles, halfword cycles or a single word cycle. Narrow write data is steered down onto the low lanes, and narrow read data is moved back up into the correct lanes of the 32-bit result.

On every cycle it also drives odd parity for each address byte and for each driven data byte. It drives a flag that is high when the upper address byte is zero, so that slaves which only decode 24 address bits can ignore the rest. A slave stretches a cycle by holding the ready line low. If the size lines return the one invalid code, the access ends with an error and no command is issued. A one-clock done pulse closes every access.

The sequencer has six states:
- IDLE waits for a request.
- ADDR drives the address and status and samples the size lines.
- CMD asserts the command strobe.
- WAIT_READY holds the command while ready is low.
- NEXT removes command and status, which forms the trailing edge.
- DONE pulses done.

It moves between them as follows:
- IDLE goes to ADDR on a request with at least one byte enabled, or straight to DONE if no byte is enabled.
- ADDR goes to CMD on a valid size code, or to DONE with an error.
- CMD and WAIT_READY go to NEXT when ready is high, and otherwise to WAIT_READY.
- NEXT goes to ADDR while bytes remain, and to DONE when none remain.
- DONE goes to IDLE.

Top module: `bus_size_seq`

## Requirements
- R1: The size lines {ds16_n, ds32_n} decode as 11 = 8-bit port, 01 = 16-bit port, 00 = 32-bit port. The code 10 ends the access with rsp_err high during the done pulse and with no command strobe at all.
- R2: For an 8-bit port, one cycle runs for each enabled byte, in ascending byte order. Each cycle drives address bits [1:0] equal to the byte index, and write data for that byte appears on data bits 7:0. Request address bits [1:0] are ignored, and the upper address bits come from the request.
- R3: For a 16-bit port, one cycle runs for each halfword (bytes 0-1 or bytes 2-3) that holds an enabled byte, with data on bits 15:0. Address bit 0 = 0 with sbhe_n = 0 is a halfword transfer. Address bit 0 = 0 with sbhe_n = 1 is a low byte only. Address bit 0 = 1 with sbhe_n = 0 is a high byte only.
- R4: For a 32-bit port, exactly one cycle runs. In it, be_n[i] is low exactly for each enabled byte i, and the data sits on its own lanes.
- R5: Read data lands in the lanes of the enabled bytes of rsp_rdata, and every other lane of rsp_rdata reads zero.
- R6: During a command, {s0_n, s1_n} is 01 for a write and 10 for a read. bus_mio follows the request's memory flag, and the write-data enable is high only for writes.
- R7: The command strobe stays active for as long as ready is low. It is therefore active for exactly one clock more than the number of not-ready clocks.
- R8: bus_made24 is high exactly when address bits 31:24 are all zero.
- R9: Each apar bit gives odd parity over its address byte. Each dpar bit gives odd parity over its data byte while write data is driven.
- R10: rsp_done is high for exactly one clock per access. A request with no byte enabled completes with no bus cycle.
- R11: In reset and between bus cycles, cmd_n is high and {s0_n, s1_n} is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_addr | input | ADDR_W (32) | Request address, bits [1:0] ignored |
| req_wdata | input | LANES*8 (32) | Write data on natural lanes |
| req_be | input | LANES (4) | Active-high byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = IO |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Invalid size code seen, valid with rsp_done |
| rsp_rdata | output | LANES*8 (32) | Assembled read data |
| bus_addr | output | ADDR_W (32) | Bus address |
| bus_made24 | output | 1 | High when upper address byte is zero |
| bus_apar | output | ADDR_W/8 (4) | Odd address parity per byte |
| bus_mio | output | 1 | Memory (1) or IO (0) |
| bus_s0_n | output | 1 | Status bit 0, active low |
| bus_s1_n | output | 1 | Status bit 1, active low |
| bus_cmd_n | output | 1 | Command strobe, active low |
| bus_be_n | output | LANES (4) | Active-low byte enables |
| bus_sbhe_n | output | 1 | High-byte enable, active low |
| bus_wdata | output | LANES*8 (32) | Steered write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_dpar | output | LANES (4) | Odd data parity per byte |
| bus_rdata | input | LANES*8 (32) | Data returned by the slave |
| bus_ds16_n | input | 1 | Returned 16-bit size line, active low |
| bus_ds32_n | input | 1 | Returned 32-bit size line, active low |
| bus_ready | input | 1 | Returned ready, low stretches the cycle |

## Verification
The bench sweeps every one of the sixteen byte-enable patterns against all four size codes, for reads and writes, at two addresses on either side of the 24-bit boundary, with varying wait states. For each bus cycle it checks the address low bits, the sbhe_n and address bit 0 combination, and the byte enables against the pattern the requirements predict. If the lowest-pending-byte choice were wrong, bytes would run out of order or be skipped. If the halfword decode were wrong, a lone high byte would be written into the low byte of the slave's memory model. Read results are filled with junk on the unused upper lanes, so a steering error shows up as wrong bytes in rsp_rdata, and an invalid size code must end in an error with no command.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WAIT_READY,
        ST_NEXT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PW_8  = 2'd0,
        PW_16 = 2'd1,
        PW_32 = 2'd2
    } port_width_e;

endpackage

// File: rtl/bsz_size_decode.sv
module bsz_size_decode
    import bsz_pkg::*;
(
    input  logic        ds16_n,
    input  logic        ds32_n,
    output port_width_e width,
    output logic        width_ok
);

    always_comb begin
        width    = PW_8;
        width_ok = 1'b1;
        unique case ({ds16_n, ds32_n})
            2'b11: width = PW_8;
            2'b01: width = PW_16;
            2'b00: width = PW_32;
            default: begin
                width    = PW_8;
                width_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bsz_lane_plan.sv
module bsz_lane_plan
    import bsz_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    input  port_width_e      width,
    output logic [IDX_W-1:0] first,
    output logic [LANES-1:0] take,
    output logic [IDX_W-1:0] shift
);

    logic [IDX_W-1:0] pair_base;

    always_comb begin
        first = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) first = IDX_W'(i);
        end
    end

    assign pair_base = {first[IDX_W-1:1], 1'b0};

    always_comb begin
        unique case (width)
            PW_8: begin
                take  = pending & (LANES'(1) << first);
                shift = first;
            end
            PW_16: begin
                take  = pending & (LANES'(3) << pair_base);
                shift = pair_base;
            end
            default: begin
                take  = pending;
                shift = '0;
            end
        endcase
    end

endmodule

// File: rtl/bsz_odd_parity.sv
module bsz_odd_parity #(
    parameter int BYTES = 4
) (
    input  logic [BYTES*8-1:0] word,
    output logic [BYTES-1:0]   par
);

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign par[g] = ~^word[g*8 +: 8];
    end

endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
    import bsz_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int LANES  = 4,
    localparam int DATA_W = LANES * 8,
    localparam int ABYTES = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              req_write,
    input  logic              req_mem,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_made24,
    output logic [ABYTES-1:0] bus_apar,
    output logic              bus_mio,
    output logic              bus_s0_n,
    output logic              bus_s1_n,
    output logic              bus_cmd_n,
    output logic [LANES-1:0]  bus_be_n,
    output logic              bus_sbhe_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic [LANES-1:0]  bus_dpar,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ds16_n,
    input  logic              bus_ds32_n,
    input  logic              bus_ready
);

    localparam int IDX_W = $clog2(LANES);

    seq_state_e        st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [LANES-1:0]  rem_q;
    logic              write_q;
    logic              mem_q;
    logic              err_q;
    port_width_e       port_q;

    port_width_e       ds_width;
    logic              ds_ok;
    logic [IDX_W-1:0]  first;
    logic [IDX_W-1:0]  shift;
    logic [IDX_W-1:0]  hi_idx;
    logic [LANES-1:0]  take;
    logic [DATA_W-1:0] rd_shifted;
    logic [DATA_W-1:0] wr_shifted;
    logic              unused_low_addr;

    assign unused_low_addr = ^{req_addr[IDX_W-1:0], addr_q[IDX_W-1:0]};

    bsz_size_decode u_size (
        .ds16_n   (bus_ds16_n),
        .ds32_n   (bus_ds32_n),
        .width    (ds_width),
        .width_ok (ds_ok)
    );

    bsz_lane_plan #(.LANES(LANES)) u_plan (
        .pending (rem_q),
        .width   (port_q),
        .first   (first),
        .take    (take),
        .shift   (shift)
    );

    assign hi_idx     = first | IDX_W'(1);
    assign rd_shifted = bus_rdata << {shift, 3'b000};
    assign wr_shifted = wdata_q >> {shift, 3'b000};

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (req_valid) st_d = (req_be == '0) ? ST_DONE : ST_ADDR;
            ST_ADDR:       st_d = ds_ok ? ST_CMD : ST_DONE;
            ST_CMD,
            ST_WAIT_READY: st_d = bus_ready ? ST_NEXT : ST_WAIT_READY;
            ST_NEXT:       st_d = (rem_q == '0) ? ST_DONE : ST_ADDR;
            ST_DONE:       st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Access context and read assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rem_q   <= '0;
            write_q <= 1'b0;
            mem_q   <= 1'b0;
            err_q   <= 1'b0;
            port_q  <= PW_8;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        rem_q   <= req_be;
                        write_q <= req_write;
                        mem_q   <= req_mem;
                        rdata_q <= '0;
                        err_q   <= 1'b0;
                    end
                end
                ST_ADDR: begin
                    port_q <= ds_width;
                    if (!ds_ok) err_q <= 1'b1;
                end
                ST_CMD, ST_WAIT_READY: begin
                    if (bus_ready) begin
                        rem_q <= rem_q & ~take;
                        if (!write_q) begin
                            for (int j = 0; j < LANES; j++) begin
                                if (take[j]) rdata_q[j*8 +: 8] <= rd_shifted[j*8 +: 8];
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        bus_s0_n     = 1'b1;
        bus_s1_n     = 1'b1;
        bus_cmd_n    = 1'b1;
        bus_be_n     = '1;
        bus_sbhe_n   = 1'b1;
        bus_wdata_oe = 1'b0;
        rsp_done     = 1'b0;
        rsp_err      = 1'b0;
        unique case (st_q)
            ST_ADDR: begin
                bus_s0_n   = ~write_q;
                bus_s1_n   = write_q;
                bus_be_n   = ~rem_q;
                bus_sbhe_n = ~rem_q[hi_idx];
            end
            ST_CMD, ST_WAIT_READY: begin
                bus_s0_n     = ~write_q;
                bus_s1_n     = write_q;
                bus_cmd_n    = 1'b0;
                bus_be_n     = ~rem_q;
                bus_sbhe_n   = ~rem_q[hi_idx];
                bus_wdata_oe = write_q;
            end
            ST_DONE: begin
                rsp_done = 1'b1;
                rsp_err  = err_q;
            end
            default: ;
        endcase
    end

    assign bus_addr  = {addr_q[ADDR_W-1:IDX_W], first};
    assign bus_mio   = mem_q;
    assign bus_wdata = bus_wdata_oe ? wr_shifted : '0;
    assign rsp_rdata = rdata_q;

    if (ADDR_W > 24) begin : g_made_hi
        assign bus_made24 = ~|bus_addr[ADDR_W-1:24];
    end else begin : g_made_lo
        assign bus_made24 = 1'b1;
    end

    bsz_odd_parity #(.BYTES(ABYTES)) u_apar (
        .word (bus_addr),
        .par  (bus_apar)
    );

    bsz_odd_parity #(.BYTES(LANES)) u_dpar (
        .word (bus_wdata),
        .par  (bus_dpar)
    );

endmodule

// File: rtl/bsz_seq_checker.sv
module bsz_seq_checker #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cmd_n,
    input logic              bus_s0_n,
    input logic              bus_s1_n,
    input logic              bus_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic              bus_wdata_oe,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [LANES-1:0]  bus_dpar
);

    p_gap_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cmd_n) |-> (bus_s0_n && bus_s1_n));

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cmd_n && !bus_ready) |=> !bus_cmd_n);

    p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cmd_n |-> (bus_s0_n != bus_s1_n));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_err_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    p_err_no_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> ($past(bus_cmd_n) && $past(bus_cmd_n, 2)));

    for (genvar g = 0; g < LANES; g++) begin : g_dpar
        p_dpar_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wdata_oe |-> (^{bus_dpar[g], bus_wdata[g*8 +: 8]}));
    end

endmodule

bind bus_size_seq bsz_seq_checker #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cmd_n    (bus_cmd_n),
    .bus_s0_n     (bus_s0_n),
    .bus_s1_n     (bus_s1_n),
    .bus_ready    (bus_ready),
    .rsp_done     (rsp_done),
    .rsp_err      (rsp_err),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_wdata    (bus_wdata),
    .bus_dpar     (bus_dpar)
);

// File: tb/test_bus_size_seq.sv
`timescale 1ns/1ps
module test_bus_size_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic [31:0] bus_addr;
    logic        bus_made24;
    logic [3:0]  bus_apar;
    logic        bus_mio, bus_s0_n, bus_s1_n, bus_cmd_n;
    logic [3:0]  bus_be_n;
    logic        bus_sbhe_n;
    logic [31:0] bus_wdata;
    logic        bus_wdata_oe;
    logic [3:0]  bus_dpar;
    logic [31:0] bus_rdata = '0;
    logic        bus_ds16_n = 1'b1;
    logic        bus_ds32_n = 1'b1;
    logic        bus_ready = 1'b1;

    always #2 clk = ~clk;

    bus_size_seq i_bus_size_seq (.*);

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [7:0]  mem_m [4];
    logic [3:0]  exp_rem;
    logic [1:0]  cur_port;
    logic [29:0] cur_base;
    bit          cur_wr, cur_mem;
    int          cyc_seen, wait_n, wait_left, cmd_len;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] low_idx(input logic [3:0] m);
        logic [1:0] r = 2'd0;
        for (int i = 3; i >= 0; i--) if (m[i]) r = 2'(i);
        return r;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Slave model: ready, read data, and per-cycle checks
    always @(negedge clk) begin
        logic [1:0] a, lo;
        logic [3:0] tk;
        a = bus_addr[1:0];
        case (cur_port)
            2'b11:   bus_rdata <= {24'hEEEEEE, mem_m[a]};
            2'b01:   bus_rdata <= {16'hEEEE, mem_m[{a[1], 1'b1}], mem_m[{a[1], 1'b0}]};
            default: bus_rdata <= {mem_m[3], mem_m[2], mem_m[1], mem_m[0]};
        endcase
        if (!rst_n) begin
            bus_ready = 1'b1;
        end else if (bus_cmd_n) begin
            wait_left = wait_n;
            cmd_len   = 0;
            bus_ready = 1'b1;
        end else begin
            cmd_len++;
            if (wait_left > 0) begin
                bus_ready = 1'b0;
                wait_left--;
            end else begin
                bus_ready = 1'b1;
                cyc_seen++;
                lo = low_idx(exp_rem);
                chk(cur_wr ? (!bus_s0_n && bus_s1_n) : (bus_s0_n && !bus_s1_n),
                    "R6", "status", {30'b0, bus_s0_n, bus_s1_n}, {30'b0, !cur_wr, cur_wr});
                chk(bus_mio == cur_mem && bus_wdata_oe == cur_wr, "R6", "mio/oe",
                    {30'b0, bus_mio, bus_wdata_oe}, {30'b0, cur_mem, cur_wr});
                chk(cmd_len == wait_n + 1, "R7", "cmd length", 32'(cmd_len), 32'(wait_n + 1));
                chk(bus_addr[31:2] == cur_base && bus_addr[1:0] == lo, "R2", "cycle address",
                    bus_addr, {cur_base, lo});
                chk(bus_made24 == (bus_addr[31:24] == 8'h00), "R8", "made24",
                    {31'b0, bus_made24}, {31'b0, bus_addr[31:24] == 8'h00});
                for (int i = 0; i < 4; i++)
                    chk(^{bus_apar[i], bus_addr[i*8 +: 8]} == 1'b1, "R9", "address parity",
                        {28'b0, bus_apar}, 32'(i));
                if (cur_wr)
                    for (int i = 0; i < 4; i++)
                        chk(^{bus_dpar[i], bus_wdata[i*8 +: 8]} == 1'b1, "R9", "data parity",
                            {28'b0, bus_dpar}, 32'(i));
                case (cur_port)
                    2'b11: begin
                        tk = 4'b0001 << lo;
                        if (cur_wr) mem_m[lo] = bus_wdata[7:0];
                    end
                    2'b01: begin
                        tk = exp_rem & (4'b0011 << {lo[1], 1'b0});
                        chk(bus_sbhe_n == !tk[{lo[1], 1'b1}], "R3", "sbhe_n",
                            {31'b0, bus_sbhe_n}, {31'b0, !tk[{lo[1], 1'b1}]});
                        if (cur_wr) begin
                            if (!bus_addr[0]) mem_m[{lo[1], 1'b0}] = bus_wdata[7:0];
                            if (!bus_sbhe_n)  mem_m[{lo[1], 1'b1}] = bus_wdata[15:8];
                        end
                    end
                    default: begin
                        tk = exp_rem;
                        chk(bus_be_n == ~exp_rem, "R4", "byte enables",
                            {28'b0, bus_be_n}, {28'b0, ~exp_rem});
                        if (cur_wr)
                            for (int i = 0; i < 4; i++)
                                if (!bus_be_n[i]) mem_m[i] = bus_wdata[i*8 +: 8];
                    end
                endcase
                exp_rem = exp_rem & ~tk;
            end
        end
    end

    task automatic run_txn(input logic [31:0] addr, input logic [3:0] be, input bit wr,
                           input bit mem, input logic [1:0] port, input int wn);
        logic [7:0]  orig [4];
        logic [31:0] wd, exp_rd, got_mem, exp_mem;
        int          exp_cyc, t;
        bit          exp_err;
        string       tag;
        wd = 32'h9E3779B9 ^ {addr[15:0], 12'h0, be};
        for (int i = 0; i < 4; i++) begin
            orig[i]  = 8'h3C ^ 8'(i * 37) ^ addr[7:0] ^ {4'h0, be};
            mem_m[i] = orig[i];
        end
        cur_port = port; cur_base = addr[31:2]; cur_wr = wr; cur_mem = mem;
        exp_rem = be; cyc_seen = 0; wait_n = wn;
        @(negedge clk);
        bus_ds16_n = port[1]; bus_ds32_n = port[0];
        req_valid = 1'b1; req_addr = addr | {30'b0, be[3:2]};
        req_wdata = wd; req_be = be; req_write = wr; req_mem = mem;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_done && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk(t < 200, "R10", "completion", 32'(t), 32'd0);
        exp_err = (be != 4'b0) && (port == 2'b10);
        case (port)
            2'b11:   begin exp_cyc = $countones(be);                  tag = "R2"; end
            2'b01:   begin exp_cyc = int'(|be[1:0]) + int'(|be[3:2]); tag = "R3"; end
            2'b00:   begin exp_cyc = (be != 0) ? 1 : 0;               tag = "R4"; end
            default: begin exp_cyc = 0;                               tag = "R1"; end
        endcase
        if (be == 4'b0) tag = "R10";
        chk(rsp_err == exp_err, "R1", "error flag", {31'b0, rsp_err}, {31'b0, exp_err});
        chk(cyc_seen == exp_cyc, tag, "cycle count", 32'(cyc_seen), 32'(exp_cyc));
        if (!exp_err && be != 4'b0) begin
            exp_rd = '0; exp_mem = '0; got_mem = '0;
            for (int i = 0; i < 4; i++) begin
                if (be[i]) exp_rd[i*8 +: 8] = orig[i];
                exp_mem[i*8 +: 8] = be[i] ? wd[i*8 +: 8] : orig[i];
                got_mem[i*8 +: 8] = mem_m[i];
            end
            if (wr) chk(got_mem == exp_mem, tag, "written bytes", got_mem, exp_mem);
            else    chk(rsp_rdata == exp_rd, "R5", "read assembly", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk(!rsp_done, "R10", "done single pulse", {31'b0, rsp_done}, 32'd0);
        chk(bus_cmd_n && bus_s0_n && bus_s1_n, "R11", "idle bus",
            {29'b0, bus_cmd_n, bus_s0_n, bus_s1_n}, 32'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_cmd_n && bus_s0_n && bus_s1_n && !rsp_done, "R11", "reset state",
            {28'b0, bus_cmd_n, bus_s0_n, bus_s1_n, rsp_done}, 32'hE);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 16; b++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int a = 0; a < 2; a++) begin
                        run_txn(a == 0 ? 32'h00ABCD10 : 32'h56341200, 4'(b), bit'(w),
                                bit'(b[0] ^ a[0]),
                                p == 0 ? 2'b11 : p == 1 ? 2'b01 : p == 2 ? 2'b00 : 2'b10,
                                (b + p) % 3);
                    end
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule